// File: doc/BRIEF.md
# Store-and-Forward Packet Buffer with Deferred Halfword Patches

This block is the egress stage for IPv4 packets that arrive as a stream of 32-bit words. The first byte of the header is in bits 31..24 of the first word. The block stores a whole packet before it sends anything, so the real byte count is known by the time the packet leaves. When the application has sent the last payload word, it may send any number of patch words. Each patch replaces one 16-bit halfword anywhere earlier in the stored packet, which lets a later stage fix a field such as a UDP checksum without a buffer of its own. Two trailer words follow the patches and close the packet.

When the trailer has been taken in, the block writes the measured total length into the header. It then recomputes the IPv4 header checksum over the patched header and sends the packet out on a valid/ready stream. A nonzero error code in the first trailer word makes the block discard the stored packet, and nothing is sent. Patches that point outside the packet, or at an odd offset, are skipped, and a wrapping counter counts them.

Back-pressure rules: an input word is taken in on a rising edge when `in_valid` and `in_ready` are both high. `in_ready` is high while a packet is being collected. It is low from the edge that takes the second trailer word until the edge that hands over the last output word. An output word is handed over when `out_valid` and `out_ready` are both high. While `out_ready` is low, the output word and its flags hold steady.

Top module: `pkt_patch_buffer`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `bad_patch_cnt` is 0.
- R2: No word is output while a packet is still being taken in. `in_ready` is 0 in the cycle after the second trailer word is accepted of a packet that is kept. `in_ready` is 1 in the cycle after the last output word is handed over.
- R3: The total-length field (word 0, bits 15..0) is output as the packet's byte count. The count is 4*(N-1) plus the final word's byte count, where N is the number of words up to and including the one with `in_eof`. The final word's byte count is `in_bytes` on that word, and 0 means 4.
- R4: The checksum field (word 2, bits 15..0) is output as the ones'-complement of the ones'-complement sum of all header halfwords. The header is IHL words long, where IHL is word 0 bits 27..24. The checksum field counts as zero in the sum. The sum uses the header after all patches and the length write.
- R5: A word after the `in_eof` word with bit 31 = 1 is a patch. Bits 30..16 give the byte offset from the first header byte, and bits 15..0 give the new value. The patch replaces bits 31..16 of stored word offset/4 when offset bit 1 is 0, and bits 15..0 when it is 1. Patches are applied in arrival order.
- R6: A patch with an odd offset, or with offset+2 greater than the byte count, changes nothing and adds 1 to `bad_patch_cnt`. The counter changes on no other occasion.
- R7: The first word after the `in_eof` word with bit 31 = 0 is the first trailer word, and the next accepted word is the second trailer word. If bits 30..16 of the first trailer word are nonzero, the packet is discarded: nothing is output, and `in_ready` is 1 again in the next cycle.
- R8: The last output word carries `out_last` = 1 and `out_bytes` = byte count mod 4, where 0 means 4. Output data and flags stay stable while `out_valid` is high and `out_ready` is low.
- R9: Patches to the length or checksum halfwords are overridden by the values from R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can accept an input word |
| in_data | input | 32 | Packet, patch or trailer word |
| in_eof | input | 1 | Marks the last packet word (packet phase only) |
| in_bytes | input | 2 | Valid bytes in the `in_eof` word, 0 means 4 |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_data | output | 32 | Finished packet word |
| out_last | output | 1 | Final word of the packet |
| out_bytes | output | 2 | Valid bytes in the final word, 0 means 4; 0 elsewhere |
| bad_patch_cnt | output | CNT_W | Count of skipped patches, wrapping |

## Verification
The properties assume that every packet fits in the buffer (at most MAX_BYTES bytes). They also assume an IHL of at least 5 that is no larger than the packet's word count, and that the sender sends exactly two trailer words after its patches. The stimulus builds only such packets, including one of the largest size. It drives `in_eof` only on the last packet word, so patches and trailer words never carry it. Back-pressure on the output uses a pseudo-random `out_ready`, so the hold-steady rule is exercised on words that stall for many cycles.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  typedef enum logic [2:0] {
    ST_COLLECT,
    ST_PATCH,
    ST_TRAIL2,
    ST_SETLEN,
    ST_ACCUM,
    ST_WRSUM,
    ST_SEND
  } pbuf_state_e;

  localparam int WORD_W    = 32;
  localparam int HALF_W    = 16;
  localparam int LEN_WORD  = 0;
  localparam int SUM_WORD  = 2;
  localparam int ACC_W     = 21;
endpackage

// File: rtl/pbuf_store.sv
module pbuf_store #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          hi_we,
  input  logic          lo_we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [1:0] half_we;
  assign half_we = {hi_we, lo_we};

  for (genvar h = 0; h < 2; h++) begin : g_bank
    logic [15:0] bank [DEPTH];
    always_ff @(posedge clk) begin
      if (half_we[h]) bank[waddr] <= wdata[h*16 +: 16];
    end
    assign rdata[h*16 +: 16] = bank[raddr];
  end
endmodule

// File: rtl/pbuf_patch_dec.sv
module pbuf_patch_dec #(
  parameter int AW    = 9,
  parameter int LEN_W = 12
) (
  input  logic [31:0]      word,
  input  logic [LEN_W-1:0] pkt_len,
  output logic             is_patch,
  output logic             in_range,
  output logic [AW-1:0]    waddr,
  output logic             hi_sel,
  output logic [15:0]      value,
  output logic             err_nz
);
  logic [14:0] off;
  assign off      = word[30:16];
  assign is_patch = word[31];
  assign value    = word[15:0];
  assign err_nz   = |word[30:16];
  assign waddr    = off[AW+1:2];
  assign hi_sel   = ~off[1];
  assign in_range = ~off[0] && (({1'b0, off} + 16'd2) <= 16'(pkt_len));
endmodule

// File: rtl/pbuf_cksum.sv
module pbuf_cksum
  import pbuf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        add,
  input  logic        zero_lo,
  input  logic [31:0] word,
  output logic [15:0] csum
);
  logic [ACC_W-1:0] acc;
  logic [16:0]      fold1;
  logic [15:0]      fold2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc <= '0;
    else if (clear)  acc <= '0;
    else if (add)    acc <= acc + ACC_W'(word[31:16])
                          + (zero_lo ? '0 : ACC_W'(word[15:0]));
  end

  always_comb begin
    fold1 = 17'(acc[15:0]) + 17'(acc[ACC_W-1:16]);
    fold2 = fold1[15:0] + 16'(fold1[16]);
    csum  = ~fold2;
  end
endmodule

// File: rtl/pkt_patch_buffer.sv
module pkt_patch_buffer
  import pbuf_pkg::*;
#(
  parameter int MAX_BYTES = 2048,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  input  logic             in_eof,
  input  logic [1:0]       in_bytes,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_data,
  output logic             out_last,
  output logic [1:0]       out_bytes,
  output logic [CNT_W-1:0] bad_patch_cnt
);
  localparam int DEPTH = MAX_BYTES / 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int LEN_W = $clog2(MAX_BYTES + 1);

  pbuf_state_e      state;
  logic [AW-1:0]    wr_ptr;
  logic [AW:0]      nwords;
  logic [LEN_W-1:0] pkt_len;
  logic             drop_r;
  logic [AW-1:0]    idx;
  logic [3:0]       ihl_r;

  logic             take;
  logic             hi_we, lo_we;
  logic [AW-1:0]    waddr;
  logic [31:0]      wdata;
  logic [31:0]      rdata;

  logic             pd_patch, pd_ok, pd_hi, pd_err;
  logic [AW-1:0]    pd_addr;
  logic [15:0]      pd_val;
  logic [15:0]      csum;
  logic             send_last;

  assign in_ready  = (state == ST_COLLECT) || (state == ST_PATCH) || (state == ST_TRAIL2);
  assign take      = in_valid && in_ready;
  assign out_valid = (state == ST_SEND);
  assign out_data  = rdata;
  assign send_last = ({1'b0, idx} == (nwords - 1'b1));
  assign out_last  = out_valid && send_last;
  assign out_bytes = out_last ? pkt_len[1:0] : 2'd0;

  pbuf_patch_dec #(.AW(AW), .LEN_W(LEN_W)) u_dec (
    .word     (in_data),
    .pkt_len  (pkt_len),
    .is_patch (pd_patch),
    .in_range (pd_ok),
    .waddr    (pd_addr),
    .hi_sel   (pd_hi),
    .value    (pd_val),
    .err_nz   (pd_err)
  );

  pbuf_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk   (clk),
    .hi_we (hi_we),
    .lo_we (lo_we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (idx),
    .rdata (rdata)
  );

  pbuf_cksum u_sum (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (state == ST_SETLEN),
    .add     (state == ST_ACCUM),
    .zero_lo (idx == AW'(SUM_WORD)),
    .word    (rdata),
    .csum    (csum)
  );

  // single write port: packet fill, patch, length and checksum are time-exclusive
  always_comb begin
    hi_we = 1'b0;
    lo_we = 1'b0;
    waddr = wr_ptr;
    wdata = in_data;
    unique case (state)
      ST_COLLECT: begin
        hi_we = take;
        lo_we = take;
      end
      ST_PATCH: begin
        waddr = pd_addr;
        wdata = {pd_val, pd_val};
        hi_we = take && pd_patch && pd_ok && pd_hi;
        lo_we = take && pd_patch && pd_ok && !pd_hi;
      end
      ST_SETLEN: begin
        waddr = AW'(LEN_WORD);
        wdata = {16'h0, 16'(pkt_len)};
        lo_we = 1'b1;
      end
      ST_WRSUM: begin
        waddr = AW'(SUM_WORD);
        wdata = {16'h0, csum};
        lo_we = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_COLLECT;
      wr_ptr        <= '0;
      nwords        <= '0;
      pkt_len       <= '0;
      drop_r        <= 1'b0;
      idx           <= '0;
      ihl_r         <= '0;
      bad_patch_cnt <= '0;
    end else begin
      unique case (state)
        ST_COLLECT: if (take) begin
          wr_ptr <= wr_ptr + 1'b1;
          if (in_eof) begin
            pkt_len <= (LEN_W'(wr_ptr) << 2)
                     + ((in_bytes == 2'd0) ? LEN_W'(4) : LEN_W'(in_bytes));
            nwords  <= {1'b0, wr_ptr} + 1'b1;
            state   <= ST_PATCH;
          end
        end
        ST_PATCH: if (take) begin
          if (pd_patch) begin
            if (!pd_ok) bad_patch_cnt <= bad_patch_cnt + 1'b1;
          end else begin
            drop_r <= pd_err;
            state  <= ST_TRAIL2;
          end
        end
        ST_TRAIL2: if (take) begin
          wr_ptr <= '0;
          idx    <= '0;
          state  <= drop_r ? ST_COLLECT : ST_SETLEN;
        end
        ST_SETLEN: begin
          ihl_r <= rdata[27:24];
          state <= ST_ACCUM;
        end
        ST_ACCUM: begin
          if (idx == AW'(ihl_r - 4'd1)) begin
            idx   <= '0;
            state <= ST_WRSUM;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_WRSUM: state <= ST_SEND;
        ST_SEND: if (out_ready) begin
          if (send_last) begin
            idx   <= '0;
            state <= ST_COLLECT;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/pbuf_checks.sv
module pbuf_checks #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [31:0]      out_data,
  input logic             out_last,
  input logic [1:0]       out_bytes,
  input logic [CNT_W-1:0] bad_patch_cnt
);
  // R2: input is closed whenever a word is offered downstream
  a_r2_closed_while_sending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R2: input reopens right after the final word leaves
  a_r2_reopen_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

  // R8: a stalled output word holds
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_last) && $stable(out_bytes)));

  // R6: counter moves only on an accepted input word
  a_r6_cnt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(bad_patch_cnt));

  // R6: counter advances by at most one per word
  a_r6_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (bad_patch_cnt == $past(bad_patch_cnt)
                                || bad_patch_cnt == CNT_W'($past(bad_patch_cnt) + 1'b1)));
endmodule

bind pkt_patch_buffer pbuf_checks #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_data      (out_data),
  .out_last      (out_last),
  .out_bytes     (out_bytes),
  .bad_patch_cnt (bad_patch_cnt)
);

// File: tb/sim_pkt_patch_buffer.sv
module sim_pkt_patch_buffer;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [31:0] in_data = '0;
  logic in_eof = 1'b0;
  logic [1:0] in_bytes = '0;
  logic out_valid, out_ready = 1'b1;
  logic [31:0] out_data;
  logic out_last;
  logic [1:0] out_bytes;
  logic [CNT_W-1:0] bad_patch_cnt;

  always #5 clk = ~clk;

  pkt_patch_buffer #(.MAX_BYTES(2048), .CNT_W(CNT_W)) u0 (.*);

  int n_checks = 0, n_fail = 0, bad_model = 0, oidx = 0;
  bit pkt_open = 0, throttle = 0, done = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] exp_q[$];
  bit          exp_last_q[$];
  logic [1:0]  exp_bytes_q[$];
  logic [31:0] pw[$];
  int          po[$];
  logic [15:0] pv[$];
  logic [31:0] held_data;
  bit          held = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  // output ready pattern, changed away from the sampling edge
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = throttle ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  // per-cycle comparison against the reference queues
  always @(negedge clk) if (rst_n && !done) begin
    if (out_valid) begin
      chk(!pkt_open, "R2", "output during packet intake", 32'(out_valid), 32'h0);
      chk(!in_ready, "R2", "in_ready while sending", 32'(in_ready), 32'h0);
    end
    if (held) begin
      chk(out_valid && out_data == held_data, "R8", "stalled word changed", out_data, held_data);
      held = 0;
    end
    if (out_valid && !out_ready) begin
      held = 1;
      held_data = out_data;
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R7", "unexpected output word", out_data, 32'h0);
      end else begin
        logic [31:0] e; bit el; logic [1:0] eb;
        e = exp_q.pop_front(); el = exp_last_q.pop_front(); eb = exp_bytes_q.pop_front();
        if (oidx == 0)      chk(out_data == e, "R3", "word 0 (length)", out_data, e);
        else if (oidx == 2) chk(out_data == e, "R4", "word 2 (checksum)", out_data, e);
        else                chk(out_data == e, "R5", $sformatf("word %0d", oidx), out_data, e);
        chk(out_last == el, "R8", "out_last", 32'(out_last), 32'(el));
        if (el) begin
          chk(out_bytes == eb, "R8", "out_bytes", 32'(out_bytes), 32'(eb));
          oidx = 0;
        end else oidx++;
      end
    end
  end

  task automatic put(input logic [31:0] w, input bit eof, input logic [1:0] b);
    bit ok;
    in_valid = 1'b1; in_data = w; in_eof = eof; in_bytes = b;
    do begin
      @(negedge clk); ok = in_ready;
      @(posedge clk);
    end while (!ok);
    #1;
  endtask

  task automatic build(input int nw, input int ihl, input int seed);
    pw.delete(); po.delete(); pv.delete();
    for (int i = 0; i < nw; i++) begin
      if (i == 0)      pw.push_back({4'h4, 4'(ihl), 8'h00, 16'hBEEF});
      else if (i == 1) pw.push_back({16'(seed), 16'h4000});
      else if (i == 2) pw.push_back({8'h40, 8'h11, 16'hDEAD});
      else             pw.push_back(32'(seed) * 32'h9E3779B1 + 32'(i) * 32'h01000193);
    end
  endtask

  task automatic send_pkt(input logic [1:0] b, input logic [14:0] err);
    logic [15:0] hw[$];
    int nw, len, ihl, sum;
    nw  = pw.size();
    len = (nw - 1) * 4 + ((b == 0) ? 4 : int'(b));
    foreach (pw[i]) begin hw.push_back(pw[i][31:16]); hw.push_back(pw[i][15:0]); end
    foreach (po[k]) begin
      if (po[k] % 2 == 0 && po[k] + 2 <= len) hw[po[k] / 2] = pv[k];
      else bad_model++;
    end
    if (err == 0) begin
      hw[1] = 16'(len);
      hw[5] = 16'h0;
      ihl = int'(hw[0][11:8]);
      sum = 0;
      for (int i = 0; i < ihl * 2; i++) sum += int'(hw[i]);
      while (sum > 32'hFFFF) sum = (sum & 32'hFFFF) + (sum >> 16);
      hw[5] = ~16'(sum);
      for (int i = 0; i < nw; i++) begin
        exp_q.push_back({hw[2*i], hw[2*i+1]});
        exp_last_q.push_back(i == nw - 1);
        exp_bytes_q.push_back(2'(len));
      end
    end
    for (int i = 0; i < nw; i++) begin
      put(pw[i], i == nw - 1, (i == nw - 1) ? b : 2'd0);
      pkt_open = 1;
    end
    foreach (po[k]) put({1'b1, 15'(po[k]), pv[k]}, 0, 2'd0);
    put({1'b0, err, 16'h0000}, 0, 2'd0);
    put(32'h0000_C0DE, 0, 2'd0);
    pkt_open = 0;
    in_valid = 1'b0;
    @(negedge clk);
    if (err != 0)
      chk(in_ready && !out_valid, "R7", "dropped packet: reopen, no output",
          {30'h0, in_ready, out_valid}, 32'h2);
    else
      chk(!in_ready, "R2", "in_ready after trailer", 32'(in_ready), 32'h0);
    @(posedge clk); #1;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish actual=%h expected=%h", 32'h0, 32'h1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'h1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'h0);
    chk(bad_patch_cnt == '0, "R1", "bad_patch_cnt after reset", 32'(bad_patch_cnt), 32'h0);
    @(posedge clk); #1;

    // R3 R4: plain packet, full last word
    build(7, 5, 11);
    send_pkt(2'd0, 15'h0);
    wait_idle();

    // R5 R6: patches in and out of range, 3-byte tail, stalled output
    throttle = 1;
    build(9, 5, 22);
    po.push_back(30); pv.push_back(16'h1234);
    po.push_back(8);  pv.push_back(16'h3F06);
    po.push_back(32); pv.push_back(16'hA5A5);
    po.push_back(34); pv.push_back(16'hFFFF);
    send_pkt(2'd3, 15'h0);
    wait_idle();

    // R6: odd and far offsets
    build(6, 5, 33);
    po.push_back(5);   pv.push_back(16'h1111);
    po.push_back(200); pv.push_back(16'h2222);
    po.push_back(12);  pv.push_back(16'h0A0B);
    send_pkt(2'd2, 15'h0);
    wait_idle();

    // R7: error code drops the packet
    build(8, 5, 44);
    po.push_back(1000); pv.push_back(16'h3333);
    send_pkt(2'd0, 15'h0003);
    wait_idle();

    // R9: patches to length and checksum are overridden, IHL 6
    build(10, 6, 55);
    po.push_back(2);  pv.push_back(16'hFFFF);
    po.push_back(10); pv.push_back(16'h0000);
    po.push_back(20); pv.push_back(16'h7777);
    send_pkt(2'd1, 15'h0);
    wait_idle();

    // largest packet, throttled
    build(512, 5, 66);
    po.push_back(2046); pv.push_back(16'hBEAD);
    po.push_back(2048); pv.push_back(16'h0001);
    send_pkt(2'd0, 15'h0);
    wait_idle();

    // smallest header-only packet with the highest offset
    throttle = 0;
    build(5, 5, 77);
    po.push_back(32766); pv.push_back(16'h4444);
    send_pkt(2'd0, 15'h0);
    wait_idle();

    @(negedge clk);
    chk(bad_patch_cnt == CNT_W'(bad_model), "R6", "skipped patch count",
        32'(bad_patch_cnt), 32'(bad_model));
    chk(exp_q.size() == 0, "R7", "all expected words delivered", 32'(exp_q.size()), 32'h0);
    chk(in_ready && !out_valid, "R2", "idle at end", {30'h0, in_ready, out_valid}, 32'h2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule